// File: doc/BRIEF.md
# Parallel Flash Read Mode Controller

This block is the read front end of a parallel NOR flash device, written as synthesizable logic that runs on one clock. It keeps one of four read states (array, identifier, status, query table). It watches the write strobe of the bus for command bytes that move it between those states. In the array state it serves reads from a 16-word page buffer that is filled from a synchronous array memory. The address can pass straight through, or it can be held by the address-valid pin, and a 16-bit data word goes out together with its output enable toward a tristate pad.

A read configuration word chooses between page reads and single-word reads. When its bit 15 is set, a read in the main array region senses a whole 16-word page at once. Further reads that change only the four low address bits are then served from the buffer with no new sense. When bit 15 is clear, or when the address lies in the low parameter region, the block senses again whenever the full word address changes. A sense takes a fixed, parameterized number of cycles, and an internal valid flag marks when it is done.

Command FSM states: RS_ARRAY, RS_IDENT, RS_STATUS, RS_CFI, and RS_CFG_WAIT (the configuration value is pending). Each accepted write moves the FSM as follows. 0xFF goes to RS_ARRAY, 0x90 to RS_IDENT, 0x70 to RS_STATUS and 0x98 to RS_CFI. 0x60 goes to RS_CFG_WAIT. From RS_CFG_WAIT, any write goes to RS_STATUS, and every other byte also goes to RS_STATUS. Page FSM states: PG_IDLE, and PG_SENSE, which it enters on a buffer miss during an array read. It counts SENSE_CYC cycles and then goes to PG_READY, where it stays until the next miss.

Top module: `flash_read_ctrl`

## Requirements
- R1: While rst_n is low, dq_oe is 0. After reset the read state is array and the configuration word is 16'h8000, so page mode is on.
- R2: dq_oe is 1 exactly when ce_n=0, oe_n=0, we_n=1 and rst_n=1.
- R3: A write is accepted at the first rising clock edge at which we_n is 1 after being 0 at the previous edge while ce_n=0, and din is sampled at that edge. The byte din[7:0] selects the state: 8'hFF array, 8'h90 identifier, 8'h70 status, 8'h98 query table.
- R4: Any other accepted byte except 8'h60 puts the block in the status state. Array data is returned again only after 8'hFF.
- R5: After 8'h60 is accepted, the next accepted write stores its full din as the configuration word, and the block enters the status state. The configuration word changes at no other time.
- R6: In the identifier state, eff_addr[1:0] selects the read data: 0 gives 16'h00D7, 1 gives 16'h4E21, 2 gives the configuration word and 3 gives 16'h0000.
- R7: The status state (and the pending-configuration state) reads 16'h0080. The query-table state reads 16'hC000 | eff_addr[3:0].
- R8: The array word at address a is ((a*37) XOR 16'hC3A5) modulo 2^16. On a buffer miss from idle, data_valid rises at the (SENSE_CYC+1)-th rising edge after the new address is applied.
- R9: With bit 15 set and the page index (eff_addr[ADDR_W-1:4]) at least PARAM_PAGES, changing only eff_addr[3:0] keeps data_valid at 1 and gives the new word in the same cycle.
- R10: With bit 15 clear, or a page index below PARAM_PAGES, any change of the address, the low bits included, drops data_valid until a new sense completes. A change of bit 15 also forces a new sense.
- R11: While adv_n is 0 the address is transparent. While adv_n is 1 the block uses the last address seen at a clock edge with adv_n at 0.
- R12: wait_o is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Device reset, active low |
| addr | input | ADDR_W | Word address |
| ce_n | input | 1 | Chip enable, active low |
| adv_n | input | 1 | Address valid, active low; high holds the address |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| din | input | 16 | Command or configuration data in |
| dq_out | output | 16 | Read data (zero when not driven) |
| dq_oe | output | 1 | Enable of the data pad driver |
| wait_o | output | 1 | Wait indication, held low |
| data_valid | output | 1 | Read data valid |

## Verification
A configuration write that changes bit 15 and a hit test against a page that is still in the buffer can fall in the same cycle. The buffered tag still matches the address, but its mode no longer does. The bench fills a main-array page with page mode on, then clears bit 15 and reads an address inside that same page. data_valid must be 0 right after the address settles, and the word must then arrive through a single-word sense. A second overlap occurs when adv_n closes the latch while the address pins move. The bench checks that the held word and data_valid stay unchanged.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;

    typedef enum logic [2:0] {
        RS_ARRAY, RS_IDENT, RS_STATUS, RS_CFI, RS_CFG_WAIT
    } rd_state_e;

    typedef enum logic [1:0] {
        PG_IDLE, PG_SENSE, PG_READY
    } pg_state_e;

    localparam logic [7:0]  CMD_ARRAY  = 8'hFF;
    localparam logic [7:0]  CMD_IDENT  = 8'h90;
    localparam logic [7:0]  CMD_STATUS = 8'h70;
    localparam logic [7:0]  CMD_CFI    = 8'h98;
    localparam logic [7:0]  CMD_CFG    = 8'h60;
    localparam logic [15:0] CFG_RESET  = 16'h8000;
    localparam logic [15:0] STATUS_RDY = 16'h0080;

    function automatic logic [15:0] array_word(input logic [15:0] a);
        return (a * 16'd37) ^ 16'hC3A5;
    endfunction

endpackage

// File: rtl/flash_array_rom.sv
module flash_array_rom
    import flash_rd_pkg::*;
#(
    parameter int TAG_W = 6
) (
    input  logic                    clk,
    input  logic                    rd_en,
    input  logic [TAG_W-1:0]        page,
    output logic [15:0][15:0]       row_o
);
    logic [15:0][15:0] row_next;

    for (genvar w = 0; w < 16; w++) begin : g_word
        assign row_next[w] = array_word(16'({page, 4'(w)}));
    end

    always_ff @(posedge clk) begin
        if (rd_en) row_o <= row_next;
    end
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
    import flash_rd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ce_n,
    input  logic        we_n,
    input  logic [15:0] din,
    output rd_state_e   state_o,
    output logic [15:0] cfg_o
);
    rd_state_e   state, state_nx;
    logic        we_q;
    logic        wr_stb;
    logic [15:0] cfg;

    assign wr_stb = !we_q && we_n && !ce_n;

    always_comb begin
        state_nx = RS_STATUS;
        if (state != RS_CFG_WAIT) begin
            unique case (din[7:0])
                CMD_ARRAY:  state_nx = RS_ARRAY;
                CMD_IDENT:  state_nx = RS_IDENT;
                CMD_STATUS: state_nx = RS_STATUS;
                CMD_CFI:    state_nx = RS_CFI;
                CMD_CFG:    state_nx = RS_CFG_WAIT;
                default:    state_nx = RS_STATUS;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RS_ARRAY;
            cfg   <= CFG_RESET;
            we_q  <= 1'b1;
        end else begin
            we_q <= we_n;
            if (wr_stb) begin
                state <= state_nx;
                if (state == RS_CFG_WAIT) cfg <= din;
            end
        end
    end

    always_comb begin
        state_o = state;
        cfg_o   = cfg;
    end

    // R3
    arr_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && state != RS_CFG_WAIT && din[7:0] == CMD_ARRAY) |=> state == RS_ARRAY);

    // R4
    other_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && state != RS_CFG_WAIT && din[7:0] != CMD_ARRAY && din[7:0] != CMD_IDENT
         && din[7:0] != CMD_CFI && din[7:0] != CMD_CFG) |=> state == RS_STATUS);

    // R5
    cfg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg) |-> $past(state) == RS_CFG_WAIT);
endmodule

// File: rtl/flash_page_fsm.sv
module flash_page_fsm
    import flash_rd_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int SENSE_CYC = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rd_req,
    input  logic                     page_en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [15:0][15:0]        mem_row,
    output logic                     mem_rd,
    output logic [15:0]              word_o,
    output logic                     valid_o
);
    localparam int CNT_W = $clog2(SENSE_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SENSE_CYC - 1);

    pg_state_e          state;
    logic [CNT_W-1:0]   cnt;
    logic [ADDR_W-1:0]  tag;
    logic               tag_pg;
    logic [15:0][15:0]  buf_q;
    logic               hit, start;

    always_comb begin
        hit = (state == PG_READY) && (tag_pg == page_en) &&
              (page_en ? (tag[ADDR_W-1:4] == addr[ADDR_W-1:4]) : (tag == addr));
        start = rd_req && !hit && (state != PG_SENSE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= PG_IDLE;
            cnt    <= '0;
            tag    <= '0;
            tag_pg <= 1'b0;
            buf_q  <= '0;
        end else begin
            unique case (state)
                PG_IDLE, PG_READY: begin
                    if (start) begin
                        state  <= PG_SENSE;
                        cnt    <= '0;
                        tag    <= addr;
                        tag_pg <= page_en;
                    end
                end
                PG_SENSE: begin
                    if (cnt == CNT_LAST) begin
                        state <= PG_READY;
                        buf_q <= mem_row;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= PG_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_rd  = start;
        valid_o = hit;
        word_o  = buf_q[addr[3:0]];
    end

    // R8
    fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == PG_READY) |-> ($past(state) == PG_SENSE && $past(cnt) == CNT_LAST));

    // R10
    tag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PG_SENSE && $past(state) == PG_SENSE) |-> ($stable(tag) && $stable(tag_pg)));
endmodule

// File: rtl/flash_read_ctrl.sv
module flash_read_ctrl
    import flash_rd_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int SENSE_CYC   = 3,
    parameter int PARAM_PAGES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce_n,
    input  logic              adv_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [15:0]       din,
    output logic [15:0]       dq_out,
    output logic              dq_oe,
    output logic              wait_o,
    output logic              data_valid
);
    localparam int TAG_W = ADDR_W - 4;
    localparam logic [TAG_W-1:0] PARAM_TAG = TAG_W'(PARAM_PAGES);

    rd_state_e         rd_state;
    logic [15:0]       cfg;
    logic [ADDR_W-1:0] lat_addr, eff_addr;
    logic [15:0][15:0] mem_row;
    logic              mem_rd, page_en, rd_req, arr_valid;
    logic [15:0]       arr_word, rd_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      lat_addr <= '0;
        else if (!adv_n) lat_addr <= addr;
    end

    assign eff_addr = adv_n ? lat_addr : addr;
    assign page_en  = cfg[15] && (eff_addr[ADDR_W-1:4] >= PARAM_TAG);
    assign rd_req   = !ce_n && we_n && (rd_state == RS_ARRAY);

    flash_cmd_fsm u_cmd (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .din(din),
        .state_o(rd_state), .cfg_o(cfg)
    );

    flash_page_fsm #(.ADDR_W(ADDR_W), .SENSE_CYC(SENSE_CYC)) u_page (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .page_en(page_en),
        .addr(eff_addr), .mem_row(mem_row), .mem_rd(mem_rd),
        .word_o(arr_word), .valid_o(arr_valid)
    );

    flash_array_rom #(.TAG_W(TAG_W)) u_rom (
        .clk(clk), .rd_en(mem_rd), .page(eff_addr[ADDR_W-1:4]), .row_o(mem_row)
    );

    always_comb begin
        unique case (rd_state)
            RS_ARRAY: rd_data = arr_word;
            RS_IDENT: begin
                unique case (eff_addr[1:0])
                    2'd0: rd_data = 16'h00D7;
                    2'd1: rd_data = 16'h4E21;
                    2'd2: rd_data = cfg;
                    default: rd_data = 16'h0000;
                endcase
            end
            RS_CFI:  rd_data = 16'hC000 | 16'(eff_addr[3:0]);
            RS_STATUS, RS_CFG_WAIT: rd_data = STATUS_RDY;
            default: rd_data = STATUS_RDY;
        endcase
    end

    always_comb begin
        dq_oe      = rst_n && !ce_n && !oe_n && we_n;
        dq_out     = dq_oe ? rd_data : 16'h0000;
        data_valid = (rd_state == RS_ARRAY) ? arr_valid : 1'b1;
        wait_o     = 1'b0;
    end

    // R2
    oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n || ce_n) |-> !dq_oe);
endmodule

// File: tb/tb_flash_read_ctrl.sv
module tb_flash_read_ctrl;
    localparam int SENSE = 3;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [9:0]  addr;
    logic        ce_n, adv_n, we_n, oe_n;
    logic [15:0] din;
    logic [15:0] dq_out;
    logic        dq_oe, wait_o, data_valid;

    int checks = 0;
    int errors = 0;
    int m_st   = 0;          // 0 array 1 ident 2 status 3 query 4 cfg pending
    logic [15:0] m_cfg = 16'h8000;

    always #5 clk = ~clk;

    flash_read_ctrl dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .adv_n(adv_n),
        .we_n(we_n), .oe_n(oe_n), .din(din), .dq_out(dq_out), .dq_oe(dq_oe),
        .wait_o(wait_o), .data_valid(data_valid)
    );

    function automatic logic [15:0] ref_word(input logic [15:0] a);
        logic [31:0] p;
        p = 32'(a) * 32'd37;
        return p[15:0] ^ 16'hC3A5;
    endfunction

    function automatic logic [15:0] ref_read(input logic [9:0] a);
        case (m_st)
            0: return ref_word(16'(a));
            1: case (a[1:0])
                   2'd0: return 16'h00D7;
                   2'd1: return 16'h4E21;
                   2'd2: return m_cfg;
                   default: return 16'h0000;
               endcase
            3: return 16'hC000 | 16'(a[3:0]);
            default: return 16'h0080;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] d);
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b1; adv_n = 1'b0; we_n = 1'b0; din = d;
        @(negedge clk); we_n = 1'b1;
        @(negedge clk); ce_n = 1'b1;
        if (m_st == 4) begin
            m_cfg = d; m_st = 2;
        end else begin
            case (d[7:0])
                8'hFF: m_st = 0;
                8'h90: m_st = 1;
                8'h70: m_st = 2;
                8'h98: m_st = 3;
                8'h60: m_st = 4;
                default: m_st = 2;
            endcase
        end
    endtask

    task automatic rd_check(input logic [9:0] a, input string tag);
        @(negedge clk); addr = a; adv_n = 1'b0; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        #1;
        for (int i = 0; i < 30; i++) begin
            if (data_valid) break;
            @(negedge clk); #1;
        end
        chk({tag, " data"}, dq_out, ref_read(a));
        chk("R12 wait", 16'(wait_o), 16'h0);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        void'($urandom(32'd4242));
        rst_n = 1'b0; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; adv_n = 1'b0;
        addr = '0; din = '0;
        repeat (3) @(negedge clk);
        chk("R1 oe in reset", 16'(dq_oe), 16'h0);
        ce_n = 1'b1; rst_n = 1'b1;
        @(negedge clk);

        // R8 latency from idle, page 16 (main)
        addr = 10'h100; ce_n = 1'b0; oe_n = 1'b0;
        n = 0;
        for (int i = 0; i < 20; i++) begin
            @(posedge clk); #1; n++;
            if (data_valid) break;
        end
        chk("R8 latency", 16'(n), 16'(SENSE + 1));
        chk("R8 word", dq_out, ref_word(16'h100));
        chk("R2 oe on", 16'(dq_oe), 16'h1);

        // R9 page hit: low bits only
        @(negedge clk); addr = 10'h10A; #1;
        chk("R9 hit valid", 16'(data_valid), 16'h1);
        chk("R9 hit word", dq_out, ref_word(16'h10A));

        // R11 latch holds while adv_n high
        @(negedge clk); adv_n = 1'b1;
        @(negedge clk); addr = 10'h3F0; #1;
        chk("R11 held word", dq_out, ref_word(16'h10A));
        chk("R11 held valid", 16'(data_valid), 16'h1);
        rd_check(10'h3F0, "R11 transparent");

        // R2 output enable rule
        @(negedge clk); oe_n = 1'b1; #1;
        chk("R2 oe_n high", 16'(dq_oe), 16'h0);
        @(negedge clk); oe_n = 1'b0; ce_n = 1'b1; #1;
        chk("R2 ce_n high", 16'(dq_oe), 16'h0);
        we_n = 1'b0; ce_n = 1'b0; #1;
        chk("R2 we_n low", 16'(dq_oe), 16'h0);
        ce_n = 1'b1; #1; we_n = 1'b1;

        // R10 parameter region: low-bit change resenses
        rd_check(10'h012, "R10 param");
        @(negedge clk); addr = 10'h013; #1;
        chk("R10 param resense", 16'(data_valid), 16'h0);
        rd_check(10'h013, "R10 param");

        // R6 identifier, R1 reset config
        bus_write(16'h0090);
        rd_check(10'h000, "R6 id0");
        rd_check(10'h001, "R6 id1");
        rd_check(10'h002, "R1 R6 cfg reset");
        chk("R1 cfg value", ref_read(10'h002), 16'h8000);
        rd_check(10'h003, "R6 id3");

        // R7 status and query table
        bus_write(16'h0070);
        rd_check(10'h100, "R7 status");
        bus_write(16'h0098);
        rd_check(10'h005, "R7 query");
        rd_check(10'h00E, "R7 query");

        // R4 other write then R3 array command
        bus_write(16'h0040);
        rd_check(10'h100, "R4 after write");
        bus_write(16'h00FF);
        rd_check(10'h100, "R3 array");

        // R5 configuration, clears page mode
        rd_check(10'h3F0, "R5 fill page");
        bus_write(16'h0060);
        rd_check(10'h3F0, "R5 pending status");
        bus_write(16'h0000);
        bus_write(16'h0090);
        rd_check(10'h002, "R5 cfg readback");
        bus_write(16'h00FF);
        @(negedge clk); addr = 10'h3F1; adv_n = 1'b0; ce_n = 1'b0; oe_n = 1'b0; #1;
        chk("R10 mode change resense", 16'(data_valid), 16'h0);
        rd_check(10'h3F1, "R10 single");
        @(negedge clk); addr = 10'h3F2; #1;
        chk("R10 single resense", 16'(data_valid), 16'h0);
        rd_check(10'h3F2, "R10 single");

        bus_write(16'h0060);
        bus_write(16'h8000);
        bus_write(16'h00FF);

        // random mix
        for (int k = 0; k < 150; k++) begin
            int op;
            op = int'($urandom % 6);
            if (op < 3) begin
                rd_check(10'($urandom_range(0, 1023)), "R8 random read");
            end else if (op == 3) begin
                logic [7:0] c;
                case ($urandom % 5)
                    0: c = 8'hFF; 1: c = 8'h90; 2: c = 8'h70; 3: c = 8'h98;
                    default: c = 8'h41;
                endcase
                bus_write({8'h00, c});
            end else if (op == 4) begin
                bus_write(16'h0060);
                bus_write(16'($urandom));
            end else begin
                bus_write(16'h00FF);
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule